// File: doc/BRIEF.md
# Boot Handoff Register Window

This block sits on the console's 8-bit peripheral-page address bus, the secondary bus whose offset lines carry the low byte of accesses to the $21xx page. It gives the cartridge bootloader a small set of control registers there. Offsets $84-$87 hold the image select, the mapping mode, the save-RAM size code and a handoff control byte. The bootloader writes them, and it can read them back. The block drives the shared data bus only while it answers one of its own reads. It leaves the console-owned offsets $00-$83 alone.

A second region, at offsets $F0-$F2, returns an instruction sequence for the handoff. The bootloader jumps there, and the CPU fetches an indirect jump through the reset vector at $00:FFFC. The bytes are $6C, $FC, $FF. In stop mode, offset $F0 returns the single stop opcode $DB instead. The block clears its enable flag when the read of the last byte ends. That flag drives both the boot-overlay output and the window itself. From then on the loaded game sees a machine with nothing mapped in that page. Only the console reset brings the window back.

Top module: `boot_handoff_window`

## Requirements
- R1: After reset, `boot_overlay_en` and `win_active` are 1, `img_sel`, `map_mode` and `sram_code` are 0, the handoff control byte is 0 (jump mode), and `data_oe` is 0.
- R2: An access to offsets $00-$83 never asserts `data_oe`, and a write there changes no configuration output.
- R3: An access is valid only when exactly one strobe is low. `data_oe` is 1 only during a valid read (`pa_rd_n`=0, `pa_wr_n`=1) of a mapped offset while the window is active. When both strobes are low, nothing is driven or written.
- R4: A valid write latches the written byte into the register at its offset. $84 holds image select in bits [IMG_W-1:0]. $85 holds the mapping mode in bits [MAP_W-1:0]. $86 holds the SRAM size code in bits [SRAM_W-1:0]. $87 is the 8-bit handoff control byte, and its bit 0 selects stop mode. A read returns each register zero-extended to 8 bits.
- R5: In jump mode (control bit 0 = 0), reads of $F0, $F1 and $F2 return $6C, $FC and $FF.
- R6: In stop mode (control bit 0 = 1), a read of $F0 returns $DB, and $F1 and $F2 are not driven.
- R7: During the read of the final handoff byte ($F2 in jump mode, $F0 in stop mode), the byte is driven and `boot_overlay_en` stays 1. The clock edge after the read strobe rises clears `boot_overlay_en` and `win_active`.
- R8: After handoff, no B-bus access asserts `data_oe`, and writes to $84-$87 leave the configuration outputs unchanged.
- R9: Once cleared, `boot_overlay_en` and `win_active` stay 0 until reset. Reset restores the R1 state.
- R10: Offsets $88-$EF and $F3-$FF are unmapped and never drive the data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the bus strobes are assumed synchronous to it |
| rst_n | input | 1 | Console reset, synchronous, active low |
| pa_addr | input | 8 | Peripheral-page offset |
| pa_rd_n | input | 1 | Peripheral read strobe, active low |
| pa_wr_n | input | 1 | Peripheral write strobe, active low |
| data_in | input | 8 | Shared data bus, as seen by the block |
| data_out | output | 8 | Byte the block drives on reads |
| data_oe | output | 1 | Output enable for `data_out` |
| img_sel | output | IMG_W | Selected image |
| map_mode | output | MAP_W | Mapping mode code |
| sram_code | output | SRAM_W | Save-RAM size code |
| boot_overlay_en | output | 1 | Boot ROM overlay enable; low requests the image swap |
| win_active | output | 1 | Register window is live |

## Verification
On every cycle, the assertions check that the data bus is driven only during a valid read at offset $84 or above. They also check that the active window never drives after handoff, that handoff is sticky, that the enable falls only after the read strobe has risen, that each magic byte matches the mode, and that configuration changes only on an accepted write. The bench scenarios cover what the assertions cannot see. These are the register readback values, the overlay still high in the middle of the final fetch, writes that are ignored after handoff, the both-strobes case, and recovery through reset in both the jump and the stop handoff.

// File: rtl/bhw_pkg.sv
// Package: shared constants and the decode result type for the boot handoff window.
// Assumes an 8-bit peripheral offset bus.
package bhw_pkg;
    localparam logic [7:0] OP_JMP_IND = 8'h6C;  // indirect jump opcode
    localparam logic [7:0] VEC_LO     = 8'hFC;  // reset vector, low byte
    localparam logic [7:0] VEC_HI     = 8'hFF;  // reset vector, high byte
    localparam logic [7:0] OP_STOP    = 8'hDB;  // stop opcode

    typedef enum logic [1:0] {
        HIT_NONE  = 2'd0,
        HIT_REG   = 2'd1,
        HIT_MAGIC = 2'd2
    } hit_e;
endpackage

// File: rtl/bhw_decode.sv
// Module: bhw_decode
// Qualifies the strobes and classifies the offset into the register range,
// the magic range or nothing. Assumes strobes are synchronous to the clock.
module bhw_decode
    import bhw_pkg::*;
#(
    parameter logic [7:0] WIN_LO     = 8'h84,
    parameter int         NREG       = 4,
    parameter logic [7:0] MAGIC_BASE = 8'hF0,
    parameter int         NMAGIC     = 3
) (
    input  logic [7:0] pa_addr,
    input  logic       pa_rd_n,
    input  logic       pa_wr_n,
    input  logic       active,
    output logic       rd_ok,
    output logic       wr_ok,
    output hit_e       hit,
    output logic [1:0] idx
);
    localparam int REG_HI = int'(WIN_LO) + NREG - 1;
    localparam int MAG_HI = int'(MAGIC_BASE) + NMAGIC - 1;

    // Strobe qualification: exactly one strobe low, window live
    always_comb begin
        rd_ok = active && !pa_rd_n && pa_wr_n;
        wr_ok = active && !pa_wr_n && pa_rd_n;
    end

    // Range classification and index within the range
    always_comb begin
        hit = HIT_NONE;
        idx = 2'd0;
        if (int'(pa_addr) >= int'(WIN_LO) && int'(pa_addr) <= REG_HI) begin
            hit = HIT_REG;
            idx = 2'(pa_addr - WIN_LO);
        end else if (int'(pa_addr) >= int'(MAGIC_BASE) && int'(pa_addr) <= MAG_HI) begin
            hit = HIT_MAGIC;
            idx = 2'(pa_addr - MAGIC_BASE);
        end
    end
endmodule

// File: rtl/bhw_cfg_regs.sv
// Module: bhw_cfg_regs
// Holds the four bootloader control registers and their readback mux.
// Assumes idx is valid whenever hit is HIT_REG.
module bhw_cfg_regs
    import bhw_pkg::*;
#(
    parameter int IMG_W  = 4,
    parameter int MAP_W  = 2,
    parameter int SRAM_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  hit_e              hit,
    input  logic [1:0]        idx,
    input  logic [7:0]        data_in,
    output logic [IMG_W-1:0]  img_q,
    output logic [MAP_W-1:0]  map_q,
    output logic [SRAM_W-1:0] sram_q,
    output logic              stop_mode,
    output logic [7:0]        rd_byte
);
    logic [7:0] ctl_q;
    logic       wr_hit;

    // Write qualifier for the register range
    always_comb wr_hit = wr_ok && (hit == HIT_REG);

    // Register update on an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img_q  <= '0;
            map_q  <= '0;
            sram_q <= '0;
            ctl_q  <= '0;
        end else if (wr_hit) begin
            case (idx)
                2'd0:    img_q  <= data_in[IMG_W-1:0];
                2'd1:    map_q  <= data_in[MAP_W-1:0];
                2'd2:    sram_q <= data_in[SRAM_W-1:0];
                default: ctl_q  <= data_in;
            endcase
        end
    end

    // Readback mux, zero-extended
    always_comb begin
        case (idx)
            2'd0:    rd_byte = 8'(img_q);
            2'd1:    rd_byte = 8'(map_q);
            2'd2:    rd_byte = 8'(sram_q);
            default: rd_byte = ctl_q;
        endcase
        stop_mode = ctl_q[0];
    end

    // R4: configuration changes only on an accepted write
    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ($stable(img_q) && $stable(map_q) && $stable(sram_q) && $stable(ctl_q)));
endmodule

// File: rtl/bhw_handoff.sv
// Module: bhw_handoff
// Produces the magic opcode bytes and owns the enable flag that the final
// byte fetch clears when its read strobe ends. Only reset sets it again.
module bhw_handoff
    import bhw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_ok,
    input  logic       pa_rd_n,
    input  hit_e       hit,
    input  logic [1:0] idx,
    input  logic       stop_mode,
    output logic       active,
    output logic       magic_valid,
    output logic [7:0] magic_byte
);
    logic final_now;
    logic final_q;

    // Magic byte selection and validity for the current mode
    always_comb begin
        if (stop_mode) begin
            magic_valid = (idx == 2'd0);
            magic_byte  = OP_STOP;
        end else begin
            magic_valid = (idx <= 2'd2);
            case (idx)
                2'd0:    magic_byte = OP_JMP_IND;
                2'd1:    magic_byte = VEC_LO;
                default: magic_byte = VEC_HI;
            endcase
        end
        final_now = rd_ok && (hit == HIT_MAGIC) &&
                    (stop_mode ? (idx == 2'd0) : (idx == 2'd2));
    end

    // Remember a final-byte fetch; clear the enable when it ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            final_q <= 1'b0;
            active  <= 1'b1;
        end else begin
            final_q <= final_now;
            if (final_q && !final_now)
                active <= 1'b0;
        end
    end

    // R9: once cleared, the enable stays cleared until reset
    p_sticky_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !active);
    // R7: the enable falls only after the read strobe has risen
    p_end_of_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> $past(pa_rd_n));
endmodule

// File: rtl/boot_handoff_window.sv
// Module: boot_handoff_window (top)
// Bootloader register window on the peripheral page with a self-disabling
// handoff sequence. Assumes bus strobes are synchronous to clk and that the
// external bus driver uses data_oe to gate data_out.
module boot_handoff_window
    import bhw_pkg::*;
#(
    parameter int         IMG_W      = 4,
    parameter int         MAP_W      = 2,
    parameter int         SRAM_W     = 4,
    parameter logic [7:0] WIN_LO     = 8'h84,
    parameter logic [7:0] MAGIC_BASE = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        pa_addr,
    input  logic              pa_rd_n,
    input  logic              pa_wr_n,
    input  logic [7:0]        data_in,
    output logic [7:0]        data_out,
    output logic              data_oe,
    output logic [IMG_W-1:0]  img_sel,
    output logic [MAP_W-1:0]  map_mode,
    output logic [SRAM_W-1:0] sram_code,
    output logic              boot_overlay_en,
    output logic              win_active
);
    localparam int NREG   = 4;
    localparam int NMAGIC = 3;

    logic       rd_ok, wr_ok, active, stop_mode, magic_valid;
    hit_e       hit;
    logic [1:0] idx;
    logic [7:0] reg_byte, magic_byte;

    bhw_decode #(.WIN_LO(WIN_LO), .NREG(NREG), .MAGIC_BASE(MAGIC_BASE), .NMAGIC(NMAGIC)) u_dec (
        .pa_addr(pa_addr), .pa_rd_n(pa_rd_n), .pa_wr_n(pa_wr_n), .active(active),
        .rd_ok(rd_ok), .wr_ok(wr_ok), .hit(hit), .idx(idx));

    bhw_cfg_regs #(.IMG_W(IMG_W), .MAP_W(MAP_W), .SRAM_W(SRAM_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .hit(hit), .idx(idx), .data_in(data_in),
        .img_q(img_sel), .map_q(map_mode), .sram_q(sram_code),
        .stop_mode(stop_mode), .rd_byte(reg_byte));

    bhw_handoff u_hand (
        .clk(clk), .rst_n(rst_n), .rd_ok(rd_ok), .pa_rd_n(pa_rd_n), .hit(hit), .idx(idx),
        .stop_mode(stop_mode), .active(active), .magic_valid(magic_valid),
        .magic_byte(magic_byte));

    // Output enable and data selection for the block's own reads
    always_comb begin
        data_oe  = rd_ok && ((hit == HIT_REG) || (hit == HIT_MAGIC && magic_valid));
        data_out = 8'h00;
        if (data_oe)
            data_out = (hit == HIT_REG) ? reg_byte : magic_byte;
        boot_overlay_en = active;
        win_active      = active;
    end

    // R2: console-owned offsets are never answered
    p_console_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (pa_addr >= WIN_LO));
    // R3: drive only during a clean read strobe
    p_read_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!pa_rd_n && pa_wr_n));
    // R8: nothing is driven after handoff
    p_silent_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_active |-> !data_oe);
    // R5: first jump byte is the indirect jump opcode
    p_jump_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && pa_addr == MAGIC_BASE && !stop_mode) |-> (data_out == 8'h6C));
    // R6: stop mode answers with the stop opcode
    p_stop_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && pa_addr == MAGIC_BASE && stop_mode) |-> (data_out == 8'hDB));
endmodule

// File: tb/boot_handoff_window_tb.sv
module boot_handoff_window_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pa_addr = 8'h00;
    logic       pa_rd_n = 1'b1;
    logic       pa_wr_n = 1'b1;
    logic [7:0] data_in = 8'h00;
    logic [7:0] data_out;
    logic       data_oe;
    logic [3:0] img_sel;
    logic [1:0] map_mode;
    logic [3:0] sram_code;
    logic       boot_overlay_en, win_active;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    boot_handoff_window u_dut (
        .clk(clk), .rst_n(rst_n), .pa_addr(pa_addr), .pa_rd_n(pa_rd_n), .pa_wr_n(pa_wr_n),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .img_sel(img_sel),
        .map_mode(map_mode), .sram_code(sram_code), .boot_overlay_en(boot_overlay_en),
        .win_active(win_active));

    // Vector: {req[3:0], is_wr, addr[7:0], wdata[7:0], exp_oe, exp_data[7:0]}
    localparam int NV = 14;
    localparam logic [29:0] VEC [NV] = '{
        {4'd4,  1'b1, 8'h84, 8'h5A, 1'b0, 8'h00},  // R4 image select write
        {4'd4,  1'b0, 8'h84, 8'h00, 1'b1, 8'h0A},  // R4 readback, zero-extended
        {4'd4,  1'b1, 8'h85, 8'hFF, 1'b0, 8'h00},
        {4'd4,  1'b0, 8'h85, 8'h00, 1'b1, 8'h03},
        {4'd4,  1'b1, 8'h86, 8'h07, 1'b0, 8'h00},
        {4'd4,  1'b0, 8'h86, 8'h00, 1'b1, 8'h07},
        {4'd4,  1'b0, 8'h87, 8'h00, 1'b1, 8'h00},  // R4 control byte, jump mode
        {4'd2,  1'b0, 8'h83, 8'h00, 1'b0, 8'h00},  // R2 console offset
        {4'd2,  1'b1, 8'h20, 8'h11, 1'b0, 8'h00},  // R2 console write
        {4'd2,  1'b0, 8'h00, 8'h00, 1'b0, 8'h00},
        {4'd10, 1'b0, 8'h88, 8'h00, 1'b0, 8'h00},  // R10 unmapped
        {4'd10, 1'b0, 8'hF3, 8'h00, 1'b0, 8'h00},  // R10 unmapped
        {4'd5,  1'b0, 8'hF0, 8'h00, 1'b1, 8'h6C},  // R5 jump opcode
        {4'd5,  1'b0, 8'hF1, 8'h00, 1'b1, 8'hFC}   // R5 vector low byte
    };

    task automatic check(input int req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        pa_addr = a; data_in = d; pa_wr_n = 1'b0;
        @(negedge clk);
        pa_wr_n = 1'b1;
        @(negedge clk);
    endtask

    // Returns the driven byte, enable and overlay flag sampled mid-strobe
    task automatic bus_read(input logic [7:0] a, output logic [7:0] d,
                            output logic oe, output logic ovl);
        @(negedge clk);
        pa_addr = a; pa_rd_n = 1'b0;
        @(negedge clk);
        d = data_out; oe = data_oe; ovl = boot_overlay_en;
        pa_rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_reset_state();
        check(1, "overlay after reset", int'(boot_overlay_en), 1);
        check(1, "window after reset", int'(win_active), 1);
        check(1, "img after reset", int'(img_sel), 0);
        check(1, "map after reset", int'(map_mode), 0);
        check(1, "sram after reset", int'(sram_code), 0);
        check(1, "oe after reset", int'(data_oe), 0);
    endtask

    initial begin
        logic [7:0] d;
        logic oe, ovl;
        do_reset();
        check_reset_state();  // R1

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][25]) begin
                bus_write(VEC[i][24:17], VEC[i][16:9]);
            end else begin
                bus_read(VEC[i][24:17], d, oe, ovl);
                check(int'(VEC[i][29:26]), $sformatf("oe @%0h", VEC[i][24:17]), int'(oe), int'(VEC[i][8]));
                if (VEC[i][8])
                    check(int'(VEC[i][29:26]), $sformatf("data @%0h", VEC[i][24:17]), int'(d), int'(VEC[i][7:0]));
            end
        end
        check(2, "img after console write", int'(img_sel), 4'hA);

        // R3: both strobes low, no drive and no write
        @(negedge clk);
        pa_addr = 8'h84; data_in = 8'h03; pa_rd_n = 1'b0; pa_wr_n = 1'b0;
        @(negedge clk);
        check(3, "oe with both strobes", int'(data_oe), 0);
        pa_rd_n = 1'b1; pa_wr_n = 1'b1;
        @(negedge clk);
        check(3, "img after both strobes", int'(img_sel), 4'hA);

        // R7: final jump byte still returned, overlay high during fetch
        bus_read(8'hF2, d, oe, ovl);
        check(7, "final byte oe", int'(oe), 1);
        check(5, "final byte data", int'(d), 8'hFF);
        check(7, "overlay mid final fetch", int'(ovl), 1);
        check(7, "overlay after handoff", int'(boot_overlay_en), 0);
        check(7, "window after handoff", int'(win_active), 0);

        // R8: silent and read-only after handoff
        bus_read(8'h84, d, oe, ovl);
        check(8, "reg read after handoff", int'(oe), 0);
        bus_read(8'hF0, d, oe, ovl);
        check(8, "magic read after handoff", int'(oe), 0);
        bus_write(8'h84, 8'h05);
        check(8, "img after late write", int'(img_sel), 4'hA);
        repeat (5) @(negedge clk);
        check(9, "overlay stays off", int'(boot_overlay_en), 0);

        // R9: reset restores the window
        do_reset();
        check_reset_state();

        // R6: stop mode
        bus_write(8'h87, 8'h01);
        bus_read(8'h87, d, oe, ovl);
        check(4, "control readback", int'(d), 8'h01);
        bus_read(8'hF1, d, oe, ovl);
        check(6, "stop mode F1 undriven", int'(oe), 0);
        check(6, "window after F1 in stop mode", int'(win_active), 1);
        bus_read(8'hF0, d, oe, ovl);
        check(6, "stop opcode oe", int'(oe), 1);
        check(6, "stop opcode", int'(d), 8'hDB);
        check(7, "overlay mid stop fetch", int'(ovl), 1);
        check(7, "overlay after stop handoff", int'(boot_overlay_en), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule